// File: doc/BRIEF.md
# Sample Timing and Trigger Controller

This block paces analog-to-digital conversions for a multichannel acquisition front end. Software writes a 16-bit configuration word that chooses the timebase, the trigger mode, channel scanning, the gain code and the output coding. While a run is active, a sample-interval counter raises a one-cycle conversion strobe once per programmed interval. The strobe is presented with the channel to convert, the gain code and the coding flag.

The sample-interval counter has two possible clock enables. One is a fixed 1 µs tick. The other is the output pulse of a second divider, which always counts a fixed 2 MHz tick. Both ticks are single-cycle enables derived from the system clock, and the divide ratios are set by parameters.

A run can begin in one of two ways, depending on two trigger-mode bits: a software start, or a rising edge on an asynchronous external trigger input. In pretrigger mode, sampling starts from software and runs freely. The first external edge then allows a programmed number of further samples, after which sampling stops.

Top module: `acq_timer`

## Requirements
- R1: A configuration write stores bits 10..0 of the word, and bits 15..11 have no effect. The outputs follow the stored word as: gain = bits 3..1, twos_cmp = bit 0, channel = bits 6..4, scan enable = bit 7, pretrigger = bit 8, external enable = bit 9, timebase select = bit 10.
- R2: With timebase select 0, consecutive conversion strobes are interval_len × TICK1_DIV system clocks apart.
- R3: With timebase select 1, consecutive strobes are interval_len × div_len × TICK2_DIV system clocks apart.
- R4: With pretrigger 0 and external enable 0, sw_start begins a run, and the external trigger input has no effect.
- R5: With pretrigger 0 and external enable 1, a rising edge on ext_trig begins a run within 5 clocks (two synchroniser stages plus edge detection), and sw_start has no effect.
- R6: With pretrigger 1, the external enable bit has no effect, and an edge while idle does not start a run. sw_start begins continuous sampling. The first rising edge during the run permits exactly post_len further strobes, after which busy falls.
- R7: A start request while busy is ignored: the strobe spacing is not disturbed.
- R8: With scan enable 1, the channel shown with successive strobes counts down from the programmed channel to 0 and then wraps back to it. With scan enable 0, the channel stays at the programmed value.
- R9: sw_stop clears busy on the next clock. A strobe lasts exactly one cycle and never appears unless busy was high the cycle before.
- R10: After reset, busy, conv_strobe, chan, gain and twos_cmp are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word |
| interval_len | input | CNT_W | Sample interval, in sample-counter ticks |
| div_len | input | CNT_W | Divide ratio of the second divider, in 2 MHz ticks |
| post_len | input | CNT_W | Strobes allowed after the trigger in pretrigger mode |
| sw_start | input | 1 | Software start pulse |
| sw_stop | input | 1 | Software stop pulse |
| ext_trig | input | 1 | Asynchronous external trigger |
| busy | output | 1 | A run is active |
| conv_strobe | output | 1 | One-cycle conversion request |
| chan | output | 3 | Channel for the current conversion |
| gain | output | 3 | Gain code |
| twos_cmp | output | 1 | Two's-complement output coding flag |

## Verification
A wrong tick or divider count appears at once as a wrong strobe spacing, so the bench measures the gap between consecutive strobes in system clocks. A fault in the trigger mode decode appears within a few cycles of the stimulus: busy either rises when it should stay low, or stays low when it should rise. A channel-sequencing fault appears on the first strobe after the wrap point. A post-trigger count fault shows as busy falling one strobe early or late.

// File: rtl/acq_timer.sv
module acq_timer #(
  parameter int CNT_W     = 16,
  parameter int TICK1_DIV = 50,
  parameter int TICK2_DIV = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [15:0]      cfg_wdata,
  input  logic [CNT_W-1:0] interval_len,
  input  logic [CNT_W-1:0] div_len,
  input  logic [CNT_W-1:0] post_len,
  input  logic             sw_start,
  input  logic             sw_stop,
  input  logic             ext_trig,
  output logic             busy,
  output logic             conv_strobe,
  output logic [2:0]       chan,
  output logic [2:0]       gain,
  output logic             twos_cmp
);
  localparam int T1W = (TICK1_DIV > 1) ? $clog2(TICK1_DIV) : 1;
  localparam int T2W = (TICK2_DIV > 1) ? $clog2(TICK2_DIV) : 1;
  localparam logic [T1W-1:0] T1_LAST = T1W'(TICK1_DIV - 1);
  localparam logic [T2W-1:0] T2_LAST = T2W'(TICK2_DIV - 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [10:0] cfg_q;
  wire tb_sel  = cfg_q[10];
  wire ext_en  = cfg_q[9];
  wire pre_md  = cfg_q[8];
  wire scan_en = cfg_q[7];
  wire [2:0] base_ch = cfg_q[6:4];

  assign gain     = cfg_q[3:1];
  assign twos_cmp = cfg_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata[10:0];
  end

  logic [T1W-1:0] t1_cnt;
  logic [T2W-1:0] t2_cnt;
  wire tick1 = (t1_cnt == T1_LAST);
  wire tick2 = (t2_cnt == T2_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t1_cnt <= '0;
      t2_cnt <= '0;
    end else begin
      t1_cnt <= tick1 ? '0 : t1_cnt + 1'b1;
      t2_cnt <= tick2 ? '0 : t2_cnt + 1'b1;
    end
  end

  logic [CNT_W-1:0] div_cnt;
  wire div_pulse = tick2 && (div_cnt <= ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)     div_cnt <= '0;
    else if (tick2) div_cnt <= (div_cnt <= ONE) ? div_len : div_cnt - 1'b1;
  end

  logic ext_s1, ext_s2, ext_s3;
  wire ext_rise = ext_s2 & ~ext_s3;

  always_ff @(posedge clk) begin
    if (!rst_n) {ext_s1, ext_s2, ext_s3} <= '0;
    else        {ext_s1, ext_s2, ext_s3} <= {ext_trig, ext_s1, ext_s2};
  end

  logic [CNT_W-1:0] smp_cnt, post_cnt;
  logic             post_arm;
  logic             strobe_q;
  logic [2:0]       chan_q;

  wire smp_tick  = tb_sel ? div_pulse : tick1;
  wire start_req = !busy && !sw_stop &&
                   ((!pre_md && ext_en) ? ext_rise : sw_start);
  wire fire      = busy && smp_tick && (smp_cnt <= ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      smp_cnt  <= '0;
      post_arm <= 1'b0;
      post_cnt <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= fire;
      if (sw_stop) begin
        busy     <= 1'b0;
        post_arm <= 1'b0;
      end else if (start_req) begin
        busy     <= 1'b1;
        smp_cnt  <= interval_len;
        post_arm <= 1'b0;
      end else if (busy) begin
        if (smp_tick)
          smp_cnt <= (smp_cnt <= ONE) ? interval_len : smp_cnt - 1'b1;
        if (pre_md && ext_rise && !post_arm) begin
          post_arm <= 1'b1;
          post_cnt <= post_len;
        end
        if (fire && post_arm) begin
          if (post_cnt <= ONE) begin
            busy     <= 1'b0;
            post_arm <= 1'b0;
          end else begin
            post_cnt <= post_cnt - 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   chan_q <= '0;
    else if (cfg_we)              chan_q <= cfg_wdata[6:4];
    else if (start_req)           chan_q <= base_ch;
    else if (strobe_q && scan_en) chan_q <= (chan_q == 3'd0) ? base_ch : chan_q - 1'b1;
  end

  assign conv_strobe = strobe_q;
  assign chan        = chan_q;
endmodule

module acq_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [15:0] cfg_wdata,
  input logic        sw_stop,
  input logic        busy,
  input logic        conv_strobe,
  input logic [2:0]  chan,
  input logic [2:0]  gain,
  input logic        twos_cmp
);
  assert_gain_follows_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (gain == $past(cfg_wdata[3:1])) && (twos_cmp == $past(cfg_wdata[0])));

  assert_strobe_needs_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe |-> $past(busy));

  assert_strobe_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe |=> !conv_strobe);

  assert_stop_clears_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_stop |=> !busy);

  assert_chan_holds_between_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(conv_strobe) && !$past(cfg_we)) |-> $stable(chan));
endmodule

bind acq_timer acq_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .sw_stop(sw_stop), .busy(busy), .conv_strobe(conv_strobe),
  .chan(chan), .gain(gain), .twos_cmp(twos_cmp)
);

// File: tb/acq_timer_tb_top.sv
module acq_timer_tb_top;
  localparam int T1 = 4;
  localparam int T2 = 2;
  localparam int NV = 5;
  localparam logic [15:0] V_CFG [NV] = '{16'h000B, 16'hF827, 16'h0458, 16'h0403, 16'h0070};
  localparam int V_INT [NV] = '{3, 5, 2, 4, 1};
  localparam int V_DIV [NV] = '{1, 1, 3, 1, 2};

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [15:0] cfg_wdata = 0;
  logic [15:0] interval_len = 1, div_len = 1, post_len = 1;
  logic sw_start = 0, sw_stop = 0, ext_trig = 0;
  logic busy, conv_strobe, twos_cmp;
  logic [2:0] chan, gain;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  acq_timer #(.CNT_W(16), .TICK1_DIV(T1), .TICK2_DIV(T2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .interval_len(interval_len), .div_len(div_len), .post_len(post_len),
    .sw_start(sw_start), .sw_stop(sw_stop), .ext_trig(ext_trig),
    .busy(busy), .conv_strobe(conv_strobe), .chan(chan), .gain(gain),
    .twos_cmp(twos_cmp));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] w);
    @(negedge clk); cfg_we = 1; cfg_wdata = w;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); sw_start = 1;
    @(negedge clk); sw_start = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); sw_stop = 1;
    @(negedge clk); sw_stop = 0;
  endtask

  task automatic wait_strobe(output int t);
    int n = 0;
    do begin
      @(negedge clk); n++;
    end while (!conv_strobe && n < 500);
    t = conv_strobe ? cyc : -1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t1, t2, cnt;
    idle(3);
    check("R10 busy", busy, 0);
    check("R10 strobe", conv_strobe, 0);
    check("R10 chan", chan, 0);
    check("R10 gain", gain, 0);
    check("R10 twos", twos_cmp, 0);
    rst_n = 1;
    idle(2);

    // R1 R2 R3: vector walk
    for (int v = 0; v < NV; v++) begin
      write_cfg(V_CFG[v]);
      interval_len = 16'(V_INT[v]);
      div_len = 16'(V_DIV[v]);
      idle(20);
      check("R1 gain", gain, int'(V_CFG[v][3:1]));
      check("R1 twos", twos_cmp, int'(V_CFG[v][0]));
      pulse_start();
      wait_strobe(t1);
      check("R1 chan", chan, int'(V_CFG[v][6:4]));
      wait_strobe(t2);
      if (V_CFG[v][10]) check("R3 period", t2 - t1, V_INT[v] * V_DIV[v] * T2);
      else              check("R2 period", t2 - t1, V_INT[v] * T1);
      pulse_stop();
      check("R9 stop", busy, 0);
    end

    // R9: no strobes after stop
    cnt = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (conv_strobe) cnt++; end
    check("R9 quiet", cnt, 0);

    // R4: ext ignored in mode 00
    write_cfg(16'h0000); interval_len = 3;
    @(negedge clk); ext_trig = 1; idle(10); ext_trig = 0; idle(10);
    check("R4 ext ignored", busy, 0);
    pulse_start();
    check("R4 sw start", busy, 1);
    pulse_stop();

    // R7: restart while busy ignored
    interval_len = 5;
    pulse_start();
    wait_strobe(t1);
    idle(7);
    pulse_start();
    wait_strobe(t2);
    check("R7 spacing", t2 - t1, 5 * T1);
    pulse_stop();

    // R5: external start mode
    write_cfg(16'h0200); interval_len = 2;
    pulse_start(); idle(20);
    check("R5 sw ignored", busy, 0);
    @(negedge clk); ext_trig = 1; idle(5);
    check("R5 ext start", busy, 1);
    wait_strobe(t1); wait_strobe(t2);
    check("R5 period", t2 - t1, 2 * T1);
    pulse_stop(); ext_trig = 0; idle(5);

    // R8: scanning
    write_cfg(16'h00A0); interval_len = 2;
    pulse_start();
    for (int k = 0; k < 5; k++) begin
      wait_strobe(t1);
      check("R8 scan chan", chan, (k % 3 == 0) ? 2 : (k % 3 == 1) ? 1 : 0);
    end
    pulse_stop();
    write_cfg(16'h0030);
    pulse_start();
    wait_strobe(t1); wait_strobe(t1);
    check("R8 fixed chan", chan, 3);
    pulse_stop();

    // R6: pretrigger mode
    write_cfg(16'h0300); interval_len = 3; post_len = 3;
    @(negedge clk); ext_trig = 1; idle(10); ext_trig = 0; idle(10);
    check("R6 idle edge ignored", busy, 0);
    pulse_start();
    wait_strobe(t1); wait_strobe(t1);
    ext_trig = 1;
    cnt = 0;
    for (int i = 0; i < 300 && busy; i++) begin
      @(negedge clk);
      if (conv_strobe) cnt++;
    end
    check("R6 post count", cnt, 3);
    check("R6 stopped", busy, 0);
    ext_trig = 0; idle(5);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule